// File: doc/BRIEF.md
# Debug Port Reset Configuration Sampler

This block decides, once per debug reset, how an auxiliary trace and debug port comes up. Two strap inputs are watched while the dedicated debug reset is held. These are an active-low event strap and bit 0 of the message-data input. When that reset is released, the block captures both straps on the system clock. From them it latches whether the port is enabled and whether it runs at full or reduced width. It also raises a sticky flag when the straps were not steady long enough before the release.

From the latched setting the block drives one output enable per message-out pin and one use-enable per message-in pin. While the debug reset is held, or while the port is disabled, every enable is off and the port drives nothing. The debug reset pin is active low, so a port with no tool attached sits in reset. The separate system reset has no effect on any of this state. The debug reset goes through a two-flop synchronizer, and release is taken as the synchronized level going from asserted to negated.

Top module: `dbg_port_cfg_sampler`

## Requirements
- R1: After `dbg_rst_b` rises, the latched configuration appears at the outputs on the third rising clock edge. Before that edge the outputs keep their reset values.
- R2: `evt_strap_b` low at the capture edge sets `port_en` to 1. `evt_strap_b` high sets `port_en` to 0.
- R3: While `port_en` is 0, `port_full`, every bit of `mdo_oe` and every bit of `mdi_en` are 0, whatever the value of `mdi0_strap`.
- R4: When enabled with `mdi0_strap` high at capture, the port is full width: `port_full`=1, `mdo_oe`=8'hFF and `mdi_en`=2'b11.
- R5: When enabled with `mdi0_strap` low at capture, the port is reduced width: `port_full`=0 and `mdo_oe`=8'h03, so only message-out pins 0 and 1 are enabled. `mdi_en`=2'b01, so message-in pin 1 stays inactive.
- R6: Once `dbg_rst_b` is low, all outputs are 0 from the third rising edge onward and stay 0 while it remains low. The setting held before that edge persists until then.
- R7: `sys_rst` has no effect on any output at any time.
- R8: `setup_viol` is set at capture in two cases. The first is a strap sample differing from the captured value on any of the four rising edges before the capture edge. The second is the synchronized debug reset having been low for fewer than four clock cycles. The enable and width are still taken from the captured values.
- R9: After capture, `setup_viol` and the configuration do not change when the straps change. Only the next debug reset clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| dbg_rst_b | input | 1 | Dedicated debug reset, active low, asynchronous to clk |
| sys_rst | input | 1 | System reset, active high, ignored by this block |
| evt_strap_b | input | 1 | Event strap, active low, enables the port |
| mdi0_strap | input | 1 | Message-data bit 0 strap, high selects full width |
| port_en | output | 1 | Port enabled |
| port_full | output | 1 | 1 = full width, 0 = reduced width |
| mdo_oe | output | 8 | Output enable per message-out pin |
| mdi_en | output | 2 | Use-enable per message-in pin |
| setup_viol | output | 1 | Sticky strap setup-window violation |

## Verification
The captured configuration is due on the third rising edge after the debug reset pin is raised. A check two edges after the release confirms that nothing has leaked out early. Assertion of the debug reset clears the outputs on its third edge, with the old setting still visible on the second. Each stimulus task pushes its expected values into a scoreboard queue, tagged with the cycle counter value at which they are due. A monitor compares them on the falling edge of that cycle, so every check falls between the edges and never on them. The strap-window boundary is hit from both sides: a change one edge before the four-sample window is accepted, and a change inside it is flagged. The same is done for reset lengths of three and four cycles.

// File: rtl/dprc_pkg.sv
`timescale 1ns/1ps
package dprc_pkg;

    localparam int unsigned MDO_PINS_DEF   = 8;
    localparam int unsigned MDI_PINS_DEF   = 2;
    localparam int unsigned MDO_RED_DEF    = 2;
    localparam int unsigned MDI_RED_DEF    = 1;
    localparam int unsigned SETUP_CLKS_DEF = 4;
    localparam int unsigned SYNC_DEF       = 2;
    localparam int unsigned STRAP_W        = 2;

    typedef enum logic {
        PORT_REDUCED = 1'b0,
        PORT_FULL    = 1'b1
    } port_width_e;

    typedef struct packed {
        logic        enabled;
        port_width_e width;
        logic        setup_bad;
    } port_cfg_t;

    localparam port_cfg_t CFG_IDLE = '{enabled: 1'b0, width: PORT_REDUCED, setup_bad: 1'b0};

    // Decode the two straps seen at the capture edge into a port setting.
    function automatic port_cfg_t capture_cfg(input logic evt_b,
                                              input logic width_sel,
                                              input logic window_ok);
        port_cfg_t c;
        c.enabled   = ~evt_b;
        c.width     = (~evt_b & width_sel) ? PORT_FULL : PORT_REDUCED;
        c.setup_bad = ~window_ok;
        return c;
    endfunction

endpackage

// File: rtl/dprc_rst_sync.sv
`timescale 1ns/1ps
module dprc_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_b_async,
    output logic rst_active,
    output logic release_pulse
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[STAGES-2:0], rst_b_async};
        last_q <= sync_q[TOP];
    end

    assign rst_active    = ~sync_q[TOP];
    assign release_pulse = sync_q[TOP] & ~last_q;

    // R1: release is a single-cycle event
    p_release_single_r1: assert property (@(posedge clk) disable iff (rst_active)
        release_pulse |=> !release_pulse);

endmodule

// File: rtl/dprc_strap_window.sv
`timescale 1ns/1ps
module dprc_strap_window #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 2
) (
    input  logic         clk,
    input  logic         sample_en,
    input  logic [W-1:0] strap_now,
    output logic         window_ok
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DEPTH-1:0][W-1:0] hist_q;
    logic [CW-1:0]           cnt_q;
    logic                    match;

    always_ff @(posedge clk) begin
        if (!sample_en) begin
            cnt_q <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-2:0], strap_now};
            if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        match = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (hist_q[i] != strap_now) match = 1'b0;
        end
    end

    assign window_ok = match && (cnt_q == FULL_CNT);

    // R8: the fill count saturates at the window depth
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!sample_en)
        cnt_q == FULL_CNT |=> cnt_q == FULL_CNT);

endmodule

// File: rtl/dprc_oe_decode.sv
`timescale 1ns/1ps
module dprc_oe_decode
    import dprc_pkg::*;
#(
    parameter int unsigned MDO_PINS = 8,
    parameter int unsigned MDI_PINS = 2,
    parameter int unsigned MDO_RED  = 2,
    parameter int unsigned MDI_RED  = 1
) (
    input  port_cfg_t            cfg,
    output logic [MDO_PINS-1:0]  mdo_oe,
    output logic [MDI_PINS-1:0]  mdi_en
);
    logic is_full;
    assign is_full = (cfg.width == PORT_FULL);

    for (genvar i = 0; i < MDO_PINS; i++) begin : g_mdo
        localparam bit IN_RED = (i < MDO_RED);
        assign mdo_oe[i] = cfg.enabled & (IN_RED | is_full);
    end

    for (genvar j = 0; j < MDI_PINS; j++) begin : g_mdi
        localparam bit IN_RED = (j < MDI_RED);
        assign mdi_en[j] = cfg.enabled & (IN_RED | is_full);
    end

endmodule

// File: rtl/dbg_port_cfg_sampler.sv
`timescale 1ns/1ps
module dbg_port_cfg_sampler
    import dprc_pkg::*;
#(
    parameter int unsigned MDO_PINS   = MDO_PINS_DEF,
    parameter int unsigned MDI_PINS   = MDI_PINS_DEF,
    parameter int unsigned MDO_RED    = MDO_RED_DEF,
    parameter int unsigned MDI_RED    = MDI_RED_DEF,
    parameter int unsigned SETUP_CLKS = SETUP_CLKS_DEF,
    parameter int unsigned SYNC_STGS  = SYNC_DEF
) (
    input  logic                clk,
    input  logic                dbg_rst_b,
    input  logic                sys_rst,
    input  logic                evt_strap_b,
    input  logic                mdi0_strap,
    output logic                port_en,
    output logic                port_full,
    output logic [MDO_PINS-1:0] mdo_oe,
    output logic [MDI_PINS-1:0] mdi_en,
    output logic                setup_viol
);
    logic      rst_active;
    logic      release_pulse;
    logic      window_ok;
    port_cfg_t cfg_q;

    dprc_rst_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk           (clk),
        .rst_b_async   (dbg_rst_b),
        .rst_active    (rst_active),
        .release_pulse (release_pulse)
    );

    dprc_strap_window #(.DEPTH(SETUP_CLKS), .W(STRAP_W)) u_window (
        .clk       (clk),
        .sample_en (rst_active),
        .strap_now ({evt_strap_b, mdi0_strap}),
        .window_ok (window_ok)
    );

    // Only the debug reset touches this register; system reset is not wired in.
    always_ff @(posedge clk) begin
        if (rst_active) begin
            cfg_q <= CFG_IDLE;
        end else if (release_pulse) begin
            cfg_q <= capture_cfg(evt_strap_b, mdi0_strap, window_ok);
        end
    end

    dprc_oe_decode #(
        .MDO_PINS (MDO_PINS),
        .MDI_PINS (MDI_PINS),
        .MDO_RED  (MDO_RED),
        .MDI_RED  (MDI_RED)
    ) u_decode (
        .cfg    (cfg_q),
        .mdo_oe (mdo_oe),
        .mdi_en (mdi_en)
    );

    assign port_en    = cfg_q.enabled;
    assign port_full  = (cfg_q.width == PORT_FULL);
    assign setup_viol = cfg_q.setup_bad;

    // R3: a disabled port enables no pin
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst_active)
        !port_en |-> (mdo_oe == '0 && mdi_en == '0 && !port_full));

    // R5: reduced width keeps the upper pins off
    p_reduced_upper_off_r5: assert property (@(posedge clk) disable iff (rst_active)
        (port_en && !port_full) |->
            (mdo_oe[MDO_PINS-1:MDO_RED] == '0 && mdi_en[MDI_PINS-1:MDI_RED] == '0));

    // R6: a held debug reset empties the port on the following edge
    p_rst_clears_r6: assert property (@(posedge clk)
        rst_active |=> (!port_en && mdo_oe == '0 && mdi_en == '0 && !setup_viol));

    // R7: system reset leaves the latched setting alone
    p_sysrst_ignored_r7: assert property (@(posedge clk) disable iff (rst_active)
        (sys_rst && !release_pulse) |=> $stable(cfg_q));

    // R9: the setup flag is sticky until the next debug reset
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst_active)
        (setup_viol && !release_pulse) |=> setup_viol);

endmodule

// File: tb/tb_dbg_port_cfg_sampler.sv
`timescale 1ns/1ps
module tb_dbg_port_cfg_sampler;

    logic       clk = 1'b0;
    logic       dbg_rst_b = 1'b0;
    logic       sys_rst = 1'b0;
    logic       evt_strap_b = 1'b1;
    logic       mdi0_strap = 1'b0;
    logic       port_en, port_full, setup_viol;
    logic [7:0] mdo_oe;
    logic [1:0] mdi_en;

    always #4 clk = ~clk;

    dbg_port_cfg_sampler dut (
        .clk         (clk),
        .dbg_rst_b   (dbg_rst_b),
        .sys_rst     (sys_rst),
        .evt_strap_b (evt_strap_b),
        .mdi0_strap  (mdi0_strap),
        .port_en     (port_en),
        .port_full   (port_full),
        .mdo_oe      (mdo_oe),
        .mdi_en      (mdi_en),
        .setup_viol  (setup_viol)
    );

    typedef struct {
        int         due;
        logic       en;
        logic       full;
        logic       viol;
        logic [7:0] mdo;
        logic [1:0] mdi;
        string      tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expected item on the falling edge of its due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            cur = sb.pop_front();
            checks++;
            if ({port_en, port_full, setup_viol, mdo_oe, mdi_en} !==
                {cur.en, cur.full, cur.viol, cur.mdo, cur.mdi}) begin
                failures++;
                $display("FAIL %s @cyc %0d: got en=%b full=%b viol=%b mdo=%h mdi=%b exp en=%b full=%b viol=%b mdo=%h mdi=%b",
                         cur.tag, cyc, port_en, port_full, setup_viol, mdo_oe, mdi_en,
                         cur.en, cur.full, cur.viol, cur.mdo, cur.mdi);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: expected values from the requirements, due d edges from now.
    task automatic expect_in(input int d, input bit en, input bit full,
                             input bit viol, input string tag);
        exp_t e;
        e.due  = cyc + d;
        e.en   = en;
        e.full = en & full;
        e.viol = viol;
        e.mdo  = !en ? 8'h00 : (full ? 8'hFF : 8'h03);
        e.mdi  = !en ? 2'b00 : (full ? 2'b11 : 2'b01);
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) step(1);
        step(1);
    endtask

    task automatic cfg_cycle(input bit evt, input bit md, input int low,
                             input bit en, input bit full, input bit viol,
                             input string tag);
        evt_strap_b = evt;
        mdi0_strap  = md;
        dbg_rst_b   = 1'b0;
        step(low);
        dbg_rst_b = 1'b1;
        expect_in(2, 1'b0, 1'b0, 1'b0, {tag, " R1 not yet captured"});
        expect_in(3, en, full, viol, tag);
        drain();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1: run did not finish, got hung exp done");
            summary();
            $finish;
        end
    end

    initial begin
        step(6);
        expect_in(1, 1'b0, 1'b0, 1'b0, "R6 reset state with no tool");
        drain();

        cfg_cycle(1'b0, 1'b1, 8, 1'b1, 1'b1, 1'b0, "R2 R4 full port");

        sys_rst = 1'b1;
        step(5);
        expect_in(1, 1'b1, 1'b1, 1'b0, "R7 sys_rst held high");
        drain();
        sys_rst = 1'b0;

        evt_strap_b = 1'b1;
        mdi0_strap  = 1'b0;
        step(4);
        expect_in(1, 1'b1, 1'b1, 1'b0, "R9 straps ignored after capture");
        drain();

        dbg_rst_b = 1'b0;
        expect_in(2, 1'b1, 1'b1, 1'b0, "R6 setting held before clear");
        expect_in(3, 1'b0, 1'b0, 1'b0, "R6 outputs cleared");
        drain();
        sys_rst = 1'b1;
        step(4);
        expect_in(1, 1'b0, 1'b0, 1'b0, "R6 R7 stays clear during reset");
        drain();
        sys_rst = 1'b0;

        cfg_cycle(1'b0, 1'b0, 8, 1'b1, 1'b0, 1'b0, "R2 R5 reduced port");
        cfg_cycle(1'b1, 1'b1, 8, 1'b0, 1'b0, 1'b0, "R2 R3 disabled full strap");
        cfg_cycle(1'b1, 1'b0, 8, 1'b0, 1'b0, 1'b0, "R3 disabled reduced strap");

        // R8: strap moves inside the window, after release
        evt_strap_b = 1'b0;
        mdi0_strap  = 1'b1;
        dbg_rst_b   = 1'b0;
        step(8);
        dbg_rst_b = 1'b1;
        step(1);
        mdi0_strap = 1'b0;
        expect_in(2, 1'b1, 1'b0, 1'b1, "R8 strap moved in window");
        drain();
        step(10);
        sys_rst = 1'b1;
        expect_in(2, 1'b1, 1'b0, 1'b1, "R9 flag sticky");
        drain();
        sys_rst = 1'b0;

        // R8 boundary: change just outside the window is accepted
        mdi0_strap = 1'b0;
        dbg_rst_b  = 1'b0;
        step(6);
        mdi0_strap = 1'b1;
        step(2);
        dbg_rst_b = 1'b1;
        expect_in(3, 1'b1, 1'b1, 1'b0, "R8 change before window");
        drain();

        // R8 boundary: change on the oldest window edge is flagged
        mdi0_strap = 1'b0;
        dbg_rst_b  = 1'b0;
        step(7);
        mdi0_strap = 1'b1;
        step(1);
        dbg_rst_b = 1'b1;
        expect_in(3, 1'b1, 1'b1, 1'b1, "R8 change at window edge");
        drain();

        cfg_cycle(1'b0, 1'b1, 3, 1'b1, 1'b1, 1'b1, "R8 reset three cycles");
        cfg_cycle(1'b0, 1'b1, 4, 1'b1, 1'b1, 1'b0, "R8 reset four cycles");

        cfg_cycle(1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b1, "R8 reset two cycles");
        dbg_rst_b = 1'b0;
        expect_in(3, 1'b0, 1'b0, 1'b0, "R9 flag cleared by debug reset");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule